// File: doc/BRIEF.md
# Ready-Line and Acquisition-Burst Sequencer

This block decides when a sensing acquisition burst may start and drives the ready line that the host watches before it clocks the serial port. The ready line has three states: floating, driven low and driven high. The block therefore brings out a separate drive-enable and drive level. After power-on reset, the line floats and then stays low through a calibration interval. It is driven high once calibration ends. From then on, bursts start in one of three ways: a transfer followed by sleep and a wake on select rising, a short select-low pulse that carries no serial clocks (a dummy trigger), or a free-running timer that runs while select stays high.

The serial shifter supplies a one-cycle pulse on each last-clock-edge event. The acquisition engine returns a burst-done pulse, and that pulse raises ready again. Every delay is a parameter counted in system-clock ticks. This lets a bench use small values and check exact cycle counts. The defaults assume a 100 kHz tick.

Top module: `rdy_burst_seq`

## Requirements
- R1: After reset is released, `rdy_oe_o` stays 0 for `T_PWR_FLOAT` cycles. Ready is then driven low (`rdy_oe_o`=1, `rdy_lvl_o`=0) for `T_CAL` cycles, and after that it is driven high.
- R2: A last-clock-edge pulse while select is low keeps ready high. Once `T_SLEEP_ENTRY` cycles have passed after the latest such pulse, `sleep_o` becomes 1 and ready is driven low. A further pulse during that wait restarts the wait.
- R3: In sleep, select sampled high clears `sleep_o` on the next cycle and floats ready for `T_WAKE_FLOAT` cycles. Ready is then driven low, and `burst_start_o` pulses `T_WAKE_BURST` cycles after the wake edge.
- R4: If select stays low in sleep, the block wakes by itself after `T_SLEEP_MAX` cycles, with the same float and burst timing as R3.
- R5: A select-low pulse of W sampled cycles with T_DUMMY_MIN <= W <= T_DUMMY_MAX and no last-clock-edge pulse is a dummy trigger. Ready is driven low in the cycle after select is sampled high, and `burst_start_o` pulses `T_DUMMY_BURST` cycles after that edge.
- R6: A select-low pulse with no clock edge and W below `T_DUMMY_MIN` or above `T_DUMMY_MAX` is ignored. Ready stays driven high and no burst starts.
- R7: `burst_start_o` is a one-cycle pulse, and ready is driven low while a burst runs. A `burst_done_i` pulse during a burst drives ready high in the next cycle.
- R8: While select stays high, a burst starts `T_FREE_RUN` cycles after ready was last driven high.
- R9: If select falls in the same cycle that the free-running interval ends, the select fall wins: no burst starts and ready stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| sel_i | input | 1 | Synchronized select line, high when idle |
| xfer_edge_i | input | 1 | One-cycle pulse on the last serial clock edge |
| burst_done_i | input | 1 | One-cycle pulse when the acquisition burst completes |
| rdy_oe_o | output | 1 | Ready drive enable, 0 means floating |
| rdy_lvl_o | output | 1 | Ready level when driven |
| burst_start_o | output | 1 | One-cycle pulse that starts an acquisition burst |
| sleep_o | output | 1 | High while the block is in sleep |

## Verification
Two things can land on the same clock edge: the free-running interval can expire in the cycle where the host pulls select low. The bench provokes this by dropping select so that it is first sampled low on exactly the edge `T_FREE_RUN` cycles after ready rose. It then judges the result by two facts: no burst pulse appears, and ready remains driven high. As a control, the same interval with select held high must produce the burst pulse on that edge.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  typedef enum logic [3:0] {
    ST_PWR_FLOAT = 4'd0,
    ST_CAL       = 4'd1,
    ST_IDLE      = 4'd2,
    ST_SEL_LOW   = 4'd3,
    ST_XFER      = 4'd4,
    ST_SLEEP     = 4'd5,
    ST_WAKE      = 4'd6,
    ST_WAKE_WAIT = 4'd7,
    ST_DUMMY     = 4'd8,
    ST_BURST     = 4'd9
  } seq_state_e;
endpackage

// File: rtl/rbs_timer.sv
module rbs_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  // R1: every interval is an exact count of ticks
  p_tick_down_r1: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/rbs_sel_monitor.sv
module rbs_sel_monitor #(
  parameter int SAT = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sel_i,
  output logic                     sel_rise,
  output logic [$clog2(SAT+1)-1:0] low_ticks
);
  localparam int WW = $clog2(SAT + 1);
  localparam logic [WW-1:0] SAT_W = WW'(SAT);

  logic sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= 1'b1;
      low_ticks <= '0;
    end else begin
      sel_q <= sel_i;
      if (sel_i)
        low_ticks <= '0;
      else if (low_ticks != SAT_W)
        low_ticks <= low_ticks + 1'b1;
    end
  end

  assign sel_rise = sel_i & ~sel_q;

  // R6: the width counter restarts once select is high again
  p_low_clear_r6: assert property (@(posedge clk) disable iff (rst)
    sel_i |=> (low_ticks == '0));
  // R6: the width counter saturates instead of wrapping
  p_low_sat_r6: assert property (@(posedge clk) disable iff (rst)
    (low_ticks <= SAT_W));
endmodule

// File: rtl/rdy_burst_seq.sv
module rdy_burst_seq
  import rbs_pkg::*;
#(
  parameter int T_PWR_FLOAT   = 2000,
  parameter int T_CAL         = 52500,
  parameter int T_SLEEP_ENTRY = 4,
  parameter int T_SLEEP_MAX   = 100000,
  parameter int T_WAKE_FLOAT  = 40,
  parameter int T_WAKE_BURST  = 92,
  parameter int T_DUMMY_MIN   = 1,
  parameter int T_DUMMY_MAX   = 1000,
  parameter int T_DUMMY_BURST = 100,
  parameter int T_FREE_RUN    = 5900
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_i,
  input  logic xfer_edge_i,
  input  logic burst_done_i,
  output logic rdy_oe_o,
  output logic rdy_lvl_o,
  output logic burst_start_o,
  output logic sleep_o
);
  localparam int TSUM = T_PWR_FLOAT + T_CAL + T_SLEEP_ENTRY + T_SLEEP_MAX +
                        T_WAKE_BURST + T_DUMMY_BURST + T_FREE_RUN;
  localparam int TW   = $clog2(TSUM + 1);
  localparam int SAT  = T_DUMMY_MAX + 1;
  localparam int WW   = $clog2(SAT + 1);

  localparam logic [TW-1:0] L_PF  = TW'(T_PWR_FLOAT - 1);
  localparam logic [TW-1:0] L_CAL = TW'(T_CAL - 1);
  localparam logic [TW-1:0] L_SE  = TW'(T_SLEEP_ENTRY - 1);
  localparam logic [TW-1:0] L_SM  = TW'(T_SLEEP_MAX - 1);
  localparam logic [TW-1:0] L_WF  = TW'(T_WAKE_FLOAT - 1);
  localparam logic [TW-1:0] L_WW  = TW'(T_WAKE_BURST - T_WAKE_FLOAT - 1);
  localparam logic [TW-1:0] L_DB  = TW'(T_DUMMY_BURST - 1);
  localparam logic [TW-1:0] L_FR  = TW'(T_FREE_RUN - 1);
  localparam logic [WW-1:0] DMIN_W = WW'(T_DUMMY_MIN);
  localparam logic [WW-1:0] DMAX_W = WW'(T_DUMMY_MAX);

  seq_state_e    state, nxt;
  logic          tmr_load, tmr_done, restart;
  logic [TW-1:0] tmr_val;
  logic          sel_rise;
  logic [WW-1:0] low_ticks;
  logic          width_ok;

  rbs_sel_monitor #(.SAT(SAT)) u_selmon (
    .clk       (clk),
    .rst       (rst),
    .sel_i     (sel_i),
    .sel_rise  (sel_rise),
    .low_ticks (low_ticks)
  );

  rbs_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  assign width_ok = (low_ticks >= DMIN_W) && (low_ticks <= DMAX_W);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_PWR_FLOAT: if (tmr_done) nxt = ST_CAL;
      ST_CAL:       if (tmr_done) nxt = ST_IDLE;
      ST_IDLE: begin
        if (!sel_i)        nxt = ST_SEL_LOW;
        else if (tmr_done) nxt = ST_BURST;
      end
      ST_SEL_LOW: begin
        if (xfer_edge_i)   nxt = ST_XFER;
        else if (sel_rise) nxt = width_ok ? ST_DUMMY : ST_IDLE;
      end
      ST_XFER:      if (tmr_done && !xfer_edge_i) nxt = ST_SLEEP;
      ST_SLEEP:     if (sel_i || tmr_done) nxt = ST_WAKE;
      ST_WAKE:      if (tmr_done) nxt = ST_WAKE_WAIT;
      ST_WAKE_WAIT: if (tmr_done) nxt = ST_BURST;
      ST_DUMMY:     if (tmr_done) nxt = ST_BURST;
      ST_BURST:     if (burst_done_i) nxt = ST_IDLE;
      default:      nxt = ST_PWR_FLOAT;
    endcase
    if (rst) nxt = ST_PWR_FLOAT;
  end

  assign restart  = (state == ST_XFER) && xfer_edge_i;
  assign tmr_load = rst || (nxt != state) || restart;

  always_comb begin
    unique case (nxt)
      ST_PWR_FLOAT: tmr_val = L_PF;
      ST_CAL:       tmr_val = L_CAL;
      ST_IDLE:      tmr_val = L_FR;
      ST_XFER:      tmr_val = L_SE;
      ST_SLEEP:     tmr_val = L_SM;
      ST_WAKE:      tmr_val = L_WF;
      ST_WAKE_WAIT: tmr_val = L_WW;
      ST_DUMMY:     tmr_val = L_DB;
      default:      tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_PWR_FLOAT;
      rdy_oe_o      <= 1'b0;
      rdy_lvl_o     <= 1'b0;
      sleep_o       <= 1'b0;
      burst_start_o <= 1'b0;
    end else begin
      state         <= nxt;
      rdy_oe_o      <= (nxt != ST_PWR_FLOAT) && (nxt != ST_WAKE);
      rdy_lvl_o     <= (nxt == ST_IDLE) || (nxt == ST_SEL_LOW) ||
                       (nxt == ST_XFER);
      sleep_o       <= (nxt == ST_SLEEP);
      burst_start_o <= (nxt == ST_BURST) && (state != ST_BURST);
    end
  end

  initial begin
    if (T_WAKE_BURST <= T_WAKE_FLOAT)
      $error("wake-to-burst delay must exceed wake float time");
  end

  // R3: select high in sleep wakes the block with ready floating
  p_wake_on_sel_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SLEEP && sel_i) |=> (!sleep_o && !rdy_oe_o));
  // R7: burst start lasts exactly one cycle
  p_burst_single_r7: assert property (@(posedge clk) disable iff (rst)
    burst_start_o |=> !burst_start_o);
  // R7: completion drives ready high on the next cycle
  p_done_ready_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BURST && burst_done_i) |=> (rdy_oe_o && rdy_lvl_o));
  // R9: a select fall in idle never yields a burst start
  p_fall_beats_free_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !sel_i) |=> !burst_start_o);
  // R2: ready stays high while the sleep-entry wait runs
  p_xfer_holds_ready_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_XFER && (!tmr_done || xfer_edge_i)) |=> (rdy_lvl_o && !sleep_o));
endmodule

// File: tb/rdy_burst_seq_test.sv
module rdy_burst_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int PF = 5, CAL = 8, SE = 4, SM = 30, WF = 3, WB = 7;
  localparam int DMIN = 3, DMAX = 10, DB = 6, FREE = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 1'b1;
  logic xfer = 1'b0;
  logic done = 1'b0;
  logic oe, lvl, bst, slp;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdy_burst_seq #(
    .T_PWR_FLOAT(PF), .T_CAL(CAL), .T_SLEEP_ENTRY(SE), .T_SLEEP_MAX(SM),
    .T_WAKE_FLOAT(WF), .T_WAKE_BURST(WB), .T_DUMMY_MIN(DMIN),
    .T_DUMMY_MAX(DMAX), .T_DUMMY_BURST(DB), .T_FREE_RUN(FREE)
  ) uut (
    .clk(clk), .rst(rst), .sel_i(sel), .xfer_edge_i(xfer),
    .burst_done_i(done), .rdy_oe_o(oe), .rdy_lvl_o(lvl),
    .burst_start_o(bst), .sleep_o(slp)
  );

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ready code: 0 float, 1 driven low, 2 driven high
  function automatic int rcode();
    return !oe ? 0 : (lvl ? 2 : 1);
  endfunction

  task automatic finish_burst(input string req);
    done = 1'b1;
    adv(1);
    done = 1'b0;
    chk(rcode() == 2, req, "ready after burst done", rcode(), 2);
  endtask

  task automatic t_powerup;
    chk(oe == 0 && bst == 0 && slp == 0, "R1", "reset outputs", {oe, bst, slp}, 0);
    rst = 1'b0;
    adv(PF - 1);
    chk(rcode() == 0, "R1", "float end", rcode(), 0);
    adv(1);
    chk(rcode() == 1, "R1", "calibration low", rcode(), 1);
    adv(CAL - 1);
    chk(rcode() == 1, "R1", "calibration end", rcode(), 1);
    adv(1);
    chk(rcode() == 2, "R1", "ready high", rcode(), 2);
  endtask

  task automatic t_free_run;
    adv(FREE - 1);
    chk(bst == 0, "R8", "no early free burst", bst, 0);
    adv(1);
    chk(bst == 1 && rcode() == 1, "R8", "free burst start", {bst, rcode()}, 5);
    adv(1);
    chk(bst == 0, "R7", "burst start single cycle", bst, 0);
    finish_burst("R7");
  endtask

  task automatic t_pulse(input int w, input bit accept);
    bit seen = 1'b0;
    sel = 1'b0;
    adv(w);
    chk(rcode() == 2, accept ? "R5" : "R6", "ready high while select low", rcode(), 2);
    sel = 1'b1;
    adv(1);
    if (accept) begin
      chk(rcode() == 1 && bst == 0, "R5", "dummy ready low", rcode(), 1);
      adv(DB - 1);
      chk(bst == 0, "R5", "dummy no early burst", bst, 0);
      adv(1);
      chk(bst == 1, "R5", "dummy burst start", bst, 1);
      finish_burst("R5");
    end else begin
      for (int i = 0; i < 12; i++) begin
        if (bst || rcode() != 2) seen = 1'b1;
        adv(1);
      end
      chk(!seen, "R6", "ignored pulse disturbed ready or burst", seen, 0);
    end
  endtask

  task automatic enter_sleep;
    sel = 1'b0;
    adv(1);
    xfer = 1'b1;
    adv(1);
    xfer = 1'b0;
    adv(1);
    xfer = 1'b1;
    adv(1);
    xfer = 1'b0;
    adv(SE - 1);
    chk(slp == 0 && rcode() == 2, "R2", "ready high before sleep", rcode(), 2);
    adv(1);
    chk(slp == 1 && rcode() == 1, "R2", "sleep with ready low", {slp, rcode()}, 5);
  endtask

  task automatic wake_tail(input string req);
    chk(slp == 0 && rcode() == 0, req, "wake floats ready", {slp, rcode()}, 0);
    sel = 1'b1;
    adv(WF - 1);
    chk(rcode() == 0, req, "float end", rcode(), 0);
    adv(1);
    chk(rcode() == 1, req, "ready driven low after float", rcode(), 1);
    adv(WB - WF - 1);
    chk(bst == 0, req, "no early wake burst", bst, 0);
    adv(1);
    chk(bst == 1, req, "wake burst start", bst, 1);
    finish_burst("R7");
  endtask

  task automatic t_wake_sel;
    enter_sleep();
    adv(5);
    sel = 1'b1;
    adv(1);
    wake_tail("R3");
  endtask

  task automatic t_sleep_max;
    enter_sleep();
    adv(SM - 1);
    chk(slp == 1, "R4", "still asleep", slp, 1);
    adv(1);
    wake_tail("R4");
  endtask

  task automatic t_collision;
    adv(FREE - 1);
    sel = 1'b0;
    adv(1);
    chk(bst == 0 && rcode() == 2, "R9", "select fall beats free burst", {bst, rcode()}, 2);
    sel = 1'b1;
    adv(1);
    chk(bst == 0 && rcode() == 2, "R9", "glitch after collision ignored", {bst, rcode()}, 2);
  endtask

  initial begin
    adv(3);
    t_powerup();
    t_free_run();
    t_pulse(5, 1'b1);
    t_pulse(DMIN, 1'b1);
    t_pulse(DMAX, 1'b1);
    t_pulse(DMIN - 1, 1'b0);
    t_pulse(DMAX + 1, 1'b0);
    t_wake_sel();
    t_sleep_max();
    t_collision();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule